// File: doc/BRIEF.md
# Write-Protect Command Sequence Decoder

This block sits beside the byte-load path of a byte-wide non-volatile memory and watches every bus write. Some writes are command steps: a given data byte written to a given address. The block matches them against a small set of unlock sequences. It decides which writes may reach the page buffer. It also raises a one-cycle request to start a self-timed chip erase, and it switches a product-identification read mode on and off. In that mode it supplies an override byte for reads of the two ID addresses.

Software write protection is on after reset. While it is on, the page buffer accepts bytes only inside a load window, and only the three-byte unlock sequence opens that window. Each accepted byte restarts the window timer. When the timer runs out the window closes, and a later load needs a fresh unlock. A six-byte sequence turns protection off. While protection is off, any write that the decoder does not take as a command step goes to the page buffer. Every command address and code is a parameter. The defaults are the usual two-address pattern: AAh to 5555h, then 55h to 2AAAh.

Top module: `wrprot_cmd_dec`

## Requirements
- R1: After reset, protection is on, no load window is open, and `load_ok`, `erase_start`, `erase_busy`, `id_mode` and `id_rd_hit` are all 0.
- R2: While protection is on and no window is open, a write to any address with any data raises no `load_ok`.
- R3: The sequence KEY_A to CMD_ADDR_A, KEY_B to CMD_ADDR_B, OP_LOAD to CMD_ADDR_A (defaults AAh@5555h, 55h@2AAAh, A0h@5555h) turns protection on and opens a load window. The three command writes give no `load_ok`. Each later write in the window gives a `load_ok` pulse in the cycle after the write.
- R4: A window stays open while the gap from the previous accepted write (or from the unlock) is at most TMO_CYCLES clock cycles. A write that arrives TMO_CYCLES+1 cycles later is refused.
- R5: The six-byte sequence KEY_A@A, KEY_B@B, OP_EXTEND@A, KEY_A@A, KEY_B@B, OP_ERASE@A (defaults 80h and 10h) gives a one-cycle `erase_start` in the cycle after the sixth write. `erase_busy` is then high for exactly ERASE_CYCLES cycles, and during that time every write is ignored.
- R6: The six-byte sequence that ends in OP_ID_ENTER (default 60h) sets `id_mode`. The three-byte sequence KEY_A@A, KEY_B@B, OP_ID_EXIT@A (default F0h) clears it.
- R7: One cycle after `rd_addr` is presented, while `id_mode` is set, address 0 gives `id_rd_hit`=1 with MFR_CODE (DAh), address 1 gives `id_rd_hit`=1 with DEV_CODE (C1h), and any other address gives `id_rd_hit`=0. Whenever `id_rd_hit`=0, `id_rd_data` is 0.
- R8: The six-byte sequence that ends in OP_UNPROTECT (default 20h) turns protection off. While protection is off, a write that is not taken as a command step is accepted and opens a window. A later three-byte unlock turns protection back on.
- R9: A write that does not match the next expected step sends the decoder back to idle. If that write is itself KEY_A to CMD_ADDR_A, it starts a new sequence.
- R10: If more than TMO_CYCLES cycles pass between two bytes of a command sequence, the partial sequence is discarded.
- R11: While a load window is open, every write is page data and no command is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle strobe for a byte-load write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address checked for an ID override |
| load_ok | output | 1 | Pulse: the previous write goes to the page buffer |
| erase_start | output | 1 | Pulse: start the chip erase |
| erase_busy | output | 1 | Self-timed erase in progress |
| id_mode | output | 1 | Product-identification read mode is active |
| id_rd_hit | output | 1 | Registered: `id_rd_data` replaces the array byte |
| id_rd_data | output | DATA_W | Registered ID byte, 0 when there is no hit |

## Verification
The bench probes the window timeout at both edges: a gap of exactly TMO_CYCLES must be accepted and a gap of one cycle more refused. An off-by-one counter fails on one side or the other. It sends a mismatching write that is itself a first key byte; a decoder that only falls back to idle would then drop the valid unlock that follows. Inside an open window it sends a complete erase sequence, which a design that decodes commands there would turn into an erase. It also counts `erase_busy` cycles exactly and writes during the erase, and it checks that the protection-off path accepts unmatched writes while still taking command bytes.

// File: rtl/wpcd_pkg.sv
package wpcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KA1,
    ST_KB1,
    ST_EXT,
    ST_KA2,
    ST_KB2
  } seq_st_t;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_UNLOCK,
    EV_ID_OFF,
    EV_ERASE,
    EV_ID_ON,
    EV_PROT_OFF
  } cmd_ev_t;

endpackage

// File: rtl/wpcd_seq.sv
module wpcd_seq
  import wpcd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CMD_ADDR_A  = 32'h5555,
  parameter int unsigned CMD_ADDR_B  = 32'h2AAA,
  parameter logic [DATA_W-1:0] KEY_A        = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B        = 8'h55,
  parameter logic [DATA_W-1:0] OP_LOAD      = 8'hA0,
  parameter logic [DATA_W-1:0] OP_EXTEND    = 8'h80,
  parameter logic [DATA_W-1:0] OP_ID_EXIT   = 8'hF0,
  parameter logic [DATA_W-1:0] OP_ERASE     = 8'h10,
  parameter logic [DATA_W-1:0] OP_ID_ENTER  = 8'h60,
  parameter logic [DATA_W-1:0] OP_UNPROTECT = 8'h20,
  parameter int unsigned TMO_CYCLES  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_ev_t           ev,
  output logic              take
);

  localparam int unsigned TW = $clog2(TMO_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(CMD_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(CMD_ADDR_B);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);

  seq_st_t st, nxt;
  logic [TW-1:0] gap_cnt;

  logic at_a, key_a_hit, key_b_hit;
  assign at_a      = (wr_addr == ADR_A);
  assign key_a_hit = at_a && (wr_data == KEY_A);
  assign key_b_hit = (wr_addr == ADR_B) && (wr_data == KEY_B);

  always_comb begin
    nxt  = ST_IDLE;
    ev   = EV_NONE;
    take = 1'b0;
    if (wr_en) begin
      unique case (st)
        ST_KA1, ST_KA2: if (key_b_hit) begin
          nxt  = (st == ST_KA1) ? ST_KB1 : ST_KB2;
          take = 1'b1;
        end
        ST_KB1: if (at_a) begin
          if (wr_data == OP_LOAD) begin
            ev = EV_UNLOCK; take = 1'b1;
          end else if (wr_data == OP_ID_EXIT) begin
            ev = EV_ID_OFF; take = 1'b1;
          end else if (wr_data == OP_EXTEND) begin
            nxt = ST_EXT; take = 1'b1;
          end
        end
        ST_EXT: if (key_a_hit) begin
          nxt = ST_KA2; take = 1'b1;
        end
        ST_KB2: if (at_a) begin
          if (wr_data == OP_ERASE) begin
            ev = EV_ERASE; take = 1'b1;
          end else if (wr_data == OP_ID_ENTER) begin
            ev = EV_ID_ON; take = 1'b1;
          end else if (wr_data == OP_UNPROTECT) begin
            ev = EV_PROT_OFF; take = 1'b1;
          end
        end
        default: ;
      endcase
      // a write that breaks the sequence may itself open a new one
      if (!take && key_a_hit) begin
        nxt  = ST_KA1;
        take = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      gap_cnt <= '0;
    end else if (wr_en) begin
      st      <= nxt;
      gap_cnt <= '0;
    end else if (st != ST_IDLE) begin
      if (gap_cnt == TMO_LAST) begin
        st      <= ST_IDLE;
        gap_cnt <= '0;
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  AST_EV_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ev != EV_NONE) |-> (wr_en && take)); // R9
  AST_EV_ENDS_SEQ: assert property (@(posedge clk) disable iff (rst)
    (ev != EV_NONE) |=> (st == ST_IDLE)); // R3
  AST_SEQ_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (gap_cnt < TW'(TMO_CYCLES))); // R10
  AST_IDLE_GAP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (gap_cnt == '0)); // R10

endmodule

// File: rtl/wpcd_gate.sv
module wpcd_gate
  import wpcd_pkg::*;
#(
  parameter int unsigned TMO_CYCLES   = 64,
  parameter int unsigned ERASE_CYCLES = 1000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_valid,
  input  logic    take,
  input  cmd_ev_t ev,
  output logic    win_open,
  output logic    load_ok,
  output logic    erase_start,
  output logic    erase_busy,
  output logic    id_mode
);

  localparam int unsigned TW = $clog2(TMO_CYCLES + 1);
  localparam int unsigned EW = $clog2(ERASE_CYCLES + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);
  localparam logic [EW-1:0] ERS_LAST = EW'(ERASE_CYCLES - 1);

  logic prot_en;
  logic [TW-1:0] win_cnt;
  logic [EW-1:0] ers_cnt;
  logic data_wr;

  assign data_wr = wr_valid && !erase_busy && (win_open || (!prot_en && !take));

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_en <= 1'b1;
      id_mode <= 1'b0;
      load_ok <= 1'b0;
    end else begin
      load_ok <= data_wr;
      unique case (ev)
        EV_UNLOCK:   prot_en <= 1'b1;
        EV_PROT_OFF: prot_en <= 1'b0;
        EV_ID_ON:    id_mode <= 1'b1;
        EV_ID_OFF:   id_mode <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
      win_cnt  <= '0;
    end else if (ev == EV_UNLOCK || data_wr) begin
      win_open <= 1'b1;
      win_cnt  <= '0;
    end else if (win_open) begin
      if (win_cnt == TMO_LAST) begin
        win_open <= 1'b0;
        win_cnt  <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      erase_start <= 1'b0;
      erase_busy  <= 1'b0;
      ers_cnt     <= '0;
    end else if (ev == EV_ERASE) begin
      erase_start <= 1'b1;
      erase_busy  <= 1'b1;
      ers_cnt     <= ERS_LAST;
    end else begin
      erase_start <= 1'b0;
      if (erase_busy) begin
        if (ers_cnt == '0) erase_busy <= 1'b0;
        else ers_cnt <= ers_cnt - 1'b1;
      end
    end
  end

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (rst)
    load_ok |-> ($past(win_open) || !$past(prot_en))); // R2
  AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start); // R5
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (erase_busy && !erase_start) |-> !load_ok); // R5
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    win_open |-> (win_cnt < TW'(TMO_CYCLES))); // R4
  AST_WIN_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    win_open |-> (ev == EV_NONE)); // R11

endmodule

// File: rtl/wpcd_idrd.sv
module wpcd_idrd #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hDA,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hC1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_rd_hit,
  output logic [DATA_W-1:0] id_rd_data
);

  logic is_mfr, is_dev;
  assign is_mfr = (rd_addr == ADDR_W'(0));
  assign is_dev = (rd_addr == ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      id_rd_hit  <= 1'b0;
      id_rd_data <= '0;
    end else begin
      id_rd_hit  <= id_mode && (is_mfr || is_dev);
      id_rd_data <= !id_mode ? '0 : is_mfr ? MFR_CODE : is_dev ? DEV_CODE : '0;
    end
  end

  AST_ID_OFF_NOHIT: assert property (@(posedge clk) disable iff (rst)
    !id_mode |=> !id_rd_hit); // R7
  AST_HIT_CODE: assert property (@(posedge clk) disable iff (rst)
    id_rd_hit |-> (id_rd_data == MFR_CODE || id_rd_data == DEV_CODE)); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !id_rd_hit |-> (id_rd_data == '0)); // R7

endmodule

// File: rtl/wrprot_cmd_dec.sv
module wrprot_cmd_dec
  import wpcd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CMD_ADDR_A   = 32'h5555,
  parameter int unsigned CMD_ADDR_B   = 32'h2AAA,
  parameter logic [DATA_W-1:0] KEY_A        = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B        = 8'h55,
  parameter logic [DATA_W-1:0] OP_LOAD      = 8'hA0,
  parameter logic [DATA_W-1:0] OP_EXTEND    = 8'h80,
  parameter logic [DATA_W-1:0] OP_ID_EXIT   = 8'hF0,
  parameter logic [DATA_W-1:0] OP_ERASE     = 8'h10,
  parameter logic [DATA_W-1:0] OP_ID_ENTER  = 8'h60,
  parameter logic [DATA_W-1:0] OP_UNPROTECT = 8'h20,
  parameter logic [DATA_W-1:0] MFR_CODE     = 8'hDA,
  parameter logic [DATA_W-1:0] DEV_CODE     = 8'hC1,
  parameter int unsigned TMO_CYCLES   = 64,
  parameter int unsigned ERASE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              load_ok,
  output logic              erase_start,
  output logic              erase_busy,
  output logic              id_mode,
  output logic              id_rd_hit,
  output logic [DATA_W-1:0] id_rd_data
);

  cmd_ev_t ev;
  logic take, win_open, seq_en;

  assign seq_en = wr_valid && !win_open && !erase_busy;

  wpcd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CMD_ADDR_A(CMD_ADDR_A), .CMD_ADDR_B(CMD_ADDR_B),
    .KEY_A(KEY_A), .KEY_B(KEY_B),
    .OP_LOAD(OP_LOAD), .OP_EXTEND(OP_EXTEND), .OP_ID_EXIT(OP_ID_EXIT),
    .OP_ERASE(OP_ERASE), .OP_ID_ENTER(OP_ID_ENTER), .OP_UNPROTECT(OP_UNPROTECT),
    .TMO_CYCLES(TMO_CYCLES)
  ) seq_i (
    .clk(clk), .rst(rst), .wr_en(seq_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .ev(ev), .take(take)
  );

  wpcd_gate #(
    .TMO_CYCLES(TMO_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) gate_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid),
    .take(take), .ev(ev), .win_open(win_open),
    .load_ok(load_ok), .erase_start(erase_start),
    .erase_busy(erase_busy), .id_mode(id_mode)
  );

  wpcd_idrd #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) idrd_i (
    .clk(clk), .rst(rst), .id_mode(id_mode), .rd_addr(rd_addr),
    .id_rd_hit(id_rd_hit), .id_rd_data(id_rd_data)
  );

endmodule

// File: tb/wrprot_cmd_dec_tb.sv
`timescale 1ns/1ps
module wrprot_cmd_dec_tb_top;

  localparam int TB_TMO = 16;
  localparam int TB_EC  = 40;
  localparam int NVEC   = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [16:0] rd_addr = 17'h1FFFF;
  logic load_ok, erase_start, erase_busy, id_mode, id_rd_hit;
  logic [7:0] id_rd_data;

  int checks = 0;
  int errors = 0;
  bit cnt_en = 1'b0;
  int busy_cnt = 0;

  always #4 clk = ~clk;

  wrprot_cmd_dec #(.TMO_CYCLES(TB_TMO), .ERASE_CYCLES(TB_EC)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .load_ok(load_ok),
    .erase_start(erase_start), .erase_busy(erase_busy), .id_mode(id_mode),
    .id_rd_hit(id_rd_hit), .id_rd_data(id_rd_data)
  );

  always @(negedge clk) if (cnt_en && erase_busy) busy_cnt++;

  // {addr[16:0], data[7:0], idle cycles after[7:0], exp load_ok, exp id_mode}
  localparam logic [34:0] VEC [NVEC] = '{
    {17'h00100, 8'h11, 8'd1,  1'b0, 1'b0}, // R2 protected, no unlock
    {17'h05555, 8'hAA, 8'd1,  1'b0, 1'b0}, // R3
    {17'h02AAA, 8'h55, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'hA0, 8'd1,  1'b0, 1'b0},
    {17'h00100, 8'h12, 8'd1,  1'b1, 1'b0}, // R3 data
    {17'h00101, 8'h34, 8'd1,  1'b1, 1'b0},
    {17'h05555, 8'hAA, 8'd20, 1'b1, 1'b0}, // R11 key byte is data
    {17'h00200, 8'h55, 8'd1,  1'b0, 1'b0}, // R4 window closed
    {17'h05555, 8'hAA, 8'd1,  1'b0, 1'b0}, // R6 enter
    {17'h02AAA, 8'h55, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'h80, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'hAA, 8'd1,  1'b0, 1'b0},
    {17'h02AAA, 8'h55, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'h60, 8'd1,  1'b0, 1'b1},
    {17'h05555, 8'hAA, 8'd1,  1'b0, 1'b1}, // R6 exit
    {17'h02AAA, 8'h55, 8'd1,  1'b0, 1'b1},
    {17'h05555, 8'hF0, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'hAA, 8'd1,  1'b0, 1'b0}, // R9 broken sequence
    {17'h01234, 8'h00, 8'd1,  1'b0, 1'b0},
    {17'h02AAA, 8'h55, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'hA0, 8'd1,  1'b0, 1'b0},
    {17'h00300, 8'h77, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'hAA, 8'd1,  1'b0, 1'b0}, // R9 restart on key
    {17'h05555, 8'hAA, 8'd1,  1'b0, 1'b0},
    {17'h02AAA, 8'h55, 8'd1,  1'b0, 1'b0},
    {17'h05555, 8'hA0, 8'd1,  1'b0, 1'b0},
    {17'h00400, 8'h99, 8'd20, 1'b1, 1'b0}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one write strobe; samples load_ok after the capturing edge
  task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic eok, input string what);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(32'(load_ok), 32'(eok), what);
  endtask

  task automatic six(input logic [7:0] op, input string what);
    wr(17'h05555, 8'hAA, 1'b0, what);
    wr(17'h02AAA, 8'h55, 1'b0, what);
    wr(17'h05555, 8'h80, 1'b0, what);
    wr(17'h05555, 8'hAA, 1'b0, what);
    wr(17'h02AAA, 8'h55, 1'b0, what);
    wr(17'h05555, op,    1'b0, what);
  endtask

  task automatic unlock(input string what);
    wr(17'h05555, 8'hAA, 1'b0, what);
    wr(17'h02AAA, 8'h55, 1'b0, what);
    wr(17'h05555, 8'hA0, 1'b0, what);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check(32'(load_ok),     0, "R1 load_ok after reset");
    check(32'(erase_start), 0, "R1 erase_start after reset");
    check(32'(erase_busy),  0, "R1 erase_busy after reset");
    check(32'(id_mode),     0, "R1 id_mode after reset");
    check(32'(id_rd_hit),   0, "R1 id_rd_hit after reset");

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][34:18], VEC[i][17:10], VEC[i][1], $sformatf("R2/R3/R6/R9/R11 vec %0d load_ok", i));
      check(32'(id_mode), 32'(VEC[i][0]), $sformatf("R6 vec %0d id_mode", i));
      check(32'(erase_start), 0, $sformatf("R5 vec %0d no erase", i));
      idle(int'(VEC[i][9:2]));
    end

    // R4 window boundary: gap TMO accepted, gap TMO+1 refused
    unlock("R4 unlock");
    idle(TB_TMO - 2);
    wr(17'h00500, 8'h01, 1'b1, "R4 gap TMO after unlock");
    idle(TB_TMO - 2);
    wr(17'h00501, 8'h02, 1'b1, "R4 gap TMO after data");
    idle(TB_TMO - 1);
    wr(17'h00502, 8'h03, 1'b0, "R4 gap TMO+1 refused");
    idle(20);

    // R10 sequence byte timeout
    wr(17'h05555, 8'hAA, 1'b0, "R10 key");
    idle(TB_TMO - 1);
    wr(17'h02AAA, 8'h55, 1'b0, "R10 late key");
    wr(17'h05555, 8'hA0, 1'b0, "R10 late op");
    wr(17'h00600, 8'h04, 1'b0, "R10 discarded sequence");
    idle(20);
    wr(17'h05555, 8'hAA, 1'b0, "R10 key");
    idle(TB_TMO - 2);
    wr(17'h02AAA, 8'h55, 1'b0, "R10 key at limit");
    wr(17'h05555, 8'hA0, 1'b0, "R10 op");
    wr(17'h00601, 8'h05, 1'b1, "R10 sequence at limit kept");
    idle(1);

    // R11 full erase pattern inside a window is only data
    wr(17'h05555, 8'hAA, 1'b1, "R11 data");
    wr(17'h02AAA, 8'h55, 1'b1, "R11 data");
    wr(17'h05555, 8'h80, 1'b1, "R11 data");
    wr(17'h05555, 8'hAA, 1'b1, "R11 data");
    wr(17'h02AAA, 8'h55, 1'b1, "R11 data");
    wr(17'h05555, 8'h10, 1'b1, "R11 data");
    check(32'(erase_busy), 0, "R11 no erase in window");
    idle(20);

    // R5 chip erase
    wr(17'h05555, 8'hAA, 1'b0, "R5 seq");
    wr(17'h02AAA, 8'h55, 1'b0, "R5 seq");
    wr(17'h05555, 8'h80, 1'b0, "R5 seq");
    wr(17'h05555, 8'hAA, 1'b0, "R5 seq");
    wr(17'h02AAA, 8'h55, 1'b0, "R5 seq");
    cnt_en = 1'b1;
    wr(17'h05555, 8'h10, 1'b0, "R5 seq");
    check(32'(erase_start), 1, "R5 erase_start pulse");
    check(32'(erase_busy),  1, "R5 erase_busy set");
    @(negedge clk);
    check(32'(erase_start), 0, "R5 erase_start one cycle");
    unlock("R5 ignored during erase");
    wr(17'h00700, 8'h06, 1'b0, "R5 write ignored during erase");
    for (int k = 0; k < 200 && erase_busy; k++) @(negedge clk);
    cnt_en = 1'b0;
    check(32'(busy_cnt), TB_EC, "R5 erase_busy length");
    unlock("R5 after erase");
    wr(17'h00701, 8'h07, 1'b1, "R5 load after erase");
    idle(20);

    // R7 ID read override
    six(8'h60, "R6 enter");
    check(32'(id_mode), 1, "R6 id_mode set");
    @(negedge clk); rd_addr = 17'h00000;
    @(negedge clk);
    check(32'(id_rd_hit), 1, "R7 hit addr 0");
    check(32'(id_rd_data), 32'hDA, "R7 mfr code");
    rd_addr = 17'h00001;
    @(negedge clk);
    check(32'(id_rd_hit), 1, "R7 hit addr 1");
    check(32'(id_rd_data), 32'hC1, "R7 dev code");
    rd_addr = 17'h00002;
    @(negedge clk);
    check(32'(id_rd_hit), 0, "R7 no hit addr 2");
    check(32'(id_rd_data), 0, "R7 zero data addr 2");
    wr(17'h05555, 8'hAA, 1'b0, "R6 exit");
    wr(17'h02AAA, 8'h55, 1'b0, "R6 exit");
    wr(17'h05555, 8'hF0, 1'b0, "R6 exit");
    check(32'(id_mode), 0, "R6 id_mode cleared");
    rd_addr = 17'h00000;
    @(negedge clk);
    @(negedge clk);
    check(32'(id_rd_hit), 0, "R7 no hit outside id mode");
    check(32'(id_rd_data), 0, "R7 zero data outside id mode");
    rd_addr = 17'h1FFFF;
    idle(2);

    // R8 protection off, then back on
    six(8'h20, "R8 unprotect");
    wr(17'h00800, 8'h08, 1'b1, "R8 plain write accepted");
    idle(20);
    wr(17'h05555, 8'hAA, 1'b0, "R8 key taken as command");
    wr(17'h00801, 8'h09, 1'b1, "R8 R9 mismatch accepted");
    idle(20);
    unlock("R8 reprotect");
    idle(20);
    wr(17'h00802, 8'h0A, 1'b0, "R8 protected again");

    summary();
    $finish;
  end

endmodule